// File: doc/BRIEF.md
# Dual-channel converter output formatter

This block sits behind one time-shared conversion path that delivers a new 8-bit result on every clock, alternating between an in-phase (I) channel and a quadrature (Q) channel. It tags each result with its channel, carries it through a fixed latency pipeline, and then places it on one or two parallel output buses. When the bus-count pin is high, bus A carries the I and Q words alternately. When it is low, bus A carries I and bus B carries Q. The I word is held back until its Q partner arrives, so both buses change together and can be captured as one 16-bit word.

The block also drives a latch clock and its complement so that downstream logic can capture the data. In single-bus mode the latch clock follows the channel of each word. In dual-bus mode it changes once per I/Q pair. An asynchronous high-impedance request releases both buses through a drive-enable output that goes to the pad drivers. Internal logic updates on the rising clock edge, and an active-high synchronous reset restarts the channel sequence.

Top module: `adc_pair_formatter`

## Requirements
- R1: The first result accepted after reset is tagged I, and tags then alternate I, Q, I, Q on successive clocks.
- R2: A result presented before rising edge n reaches the output registers at edge n+LAT_CYCLES (default 6).
- R3: In single-bus mode (one_bus high), every word appears on bus_a in arrival order. bus_b is 0, lclk is 0 after an I word and 1 after a Q word.
- R4: In dual-bus mode (one_bus low), the edge that processes an I word leaves bus_a, bus_b and lclk unchanged. The following Q edge loads the held I word onto bus_a and the Q word onto bus_b, and inverts lclk.
- R5: one_bus is taken only in the cycle in which an I word reaches the output stage. That value governs both words of the pair, whatever one_bus does on the Q cycle.
- R6: bus_en equals the inverse of hiz at all times, with no clock involved, and hiz has no effect on the data pipeline.
- R7: lclk_n is always the complement of lclk.
- R8: Reset drives bus_a, bus_b and lclk to 0, and they stay 0 until the first word after reset has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active, two per I/Q pair |
| rst | input | 1 | Synchronous reset, active high |
| conv_word | input | 8 | Converter result, straight binary, bit 7 MSB |
| one_bus | input | 1 | 1 = interleaved single bus, 0 = paired dual bus |
| hiz | input | 1 | Asynchronous request to release both buses |
| bus_a | output | 8 | Primary data bus |
| bus_b | output | 8 | Secondary data bus (Q in dual mode) |
| bus_en | output | 1 | Pad drive enable for both buses, 0 = high impedance |
| lclk | output | 1 | Data-qualifying latch clock |
| lclk_n | output | 1 | Inverse latch clock |

## Verification
The hardest situation to reach is a mode change that lands on the Q half of a pair. The pin value seen at that moment must be ignored for the pair already in flight, and this can only be observed LAT_CYCLES later on the buses. One phase of the stimulus flips one_bus on every clock, so each pair sees a different value on its I and Q cycles. A random phase changes the mode at irregular points. The bench model picks the mode sampled at each pair's I cycle and predicts the interleaved or paired result, including whether lclk holds or toggles.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
    localparam int unsigned WORD_W = 8;

    typedef struct packed {
        logic              vld;
        logic              is_q;
        logic [WORD_W-1:0] word;
    } tagged_t;
endpackage

// File: rtl/adcfmt_tagger.sv
module adcfmt_tagger
    import adcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    output tagged_t           smp_o
);
    typedef struct packed {
        logic    tog;
        tagged_t smp;
    } tag_state_t;

    tag_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.smp.vld  = 1'b1;
        st_d.smp.is_q = st_q.tog;
        st_d.smp.word = word_i;
        st_d.tog      = ~st_q.tog;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign smp_o = st_q.smp;

    // R1: the channel flag flips on every clock once out of reset
    a_r1_alternate: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (st_q.tog != $past(st_q.tog)));

    // R1: the first tagged sample after reset is an I sample
    a_r1_first_is_i: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (smp_o.is_q == 1'b0));
endmodule

// File: rtl/adcfmt_delay.sv
module adcfmt_delay
    import adcfmt_pkg::*;
#(
    parameter int unsigned DEPTH = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  tagged_t d_i,
    output tagged_t q_o
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign q_o = d_i;
        end else begin : g_line
            tagged_t stage_d [DEPTH];
            tagged_t stage_q [DEPTH];

            always_comb begin
                stage_d[0] = d_i;
                for (int i = 1; i < DEPTH; i++) begin
                    stage_d[i] = stage_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (rst) stage_q[i] <= '0;
                    else     stage_q[i] <= stage_d[i];
                end
            end

            assign q_o = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/adcfmt_pack.sv
module adcfmt_pack
    import adcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              one_bus,
    input  tagged_t           tap_i,
    output logic [WORD_W-1:0] bus_a_o,
    output logic [WORD_W-1:0] bus_b_o,
    output logic              lclk_o
);
    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] hold;
        logic              single;
        logic              lclk;
    } pack_state_t;

    pack_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tap_i.vld) begin
            if (!tap_i.is_q) begin
                // pair boundary: take the mode, park the I word
                st_d.single = one_bus;
                st_d.hold   = tap_i.word;
                if (one_bus) begin
                    st_d.a    = tap_i.word;
                    st_d.b    = '0;
                    st_d.lclk = 1'b0;
                end
            end else if (st_q.single) begin
                st_d.a    = tap_i.word;
                st_d.b    = '0;
                st_d.lclk = 1'b1;
            end else begin
                st_d.a    = st_q.hold;
                st_d.b    = tap_i.word;
                st_d.lclk = ~st_q.lclk;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bus_a_o = st_q.a;
    assign bus_b_o = st_q.b;
    assign lclk_o  = st_q.lclk;

    // R4: an I word in dual mode leaves every output untouched
    a_r4_dual_i_holds: assert property (@(posedge clk) disable iff (rst)
        (tap_i.vld && !tap_i.is_q && !one_bus) |=>
            ($stable(bus_a_o) && $stable(bus_b_o) && $stable(lclk_o)));

    // R4: the Q word of a dual pair inverts the latch clock
    a_r4_dual_q_toggle: assert property (@(posedge clk) disable iff (rst)
        (tap_i.vld && tap_i.is_q && !st_q.single) |=> (lclk_o != $past(lclk_o)));

    // R3: an I word in single mode lowers the latch clock and clears bus B
    a_r3_single_i_low: assert property (@(posedge clk) disable iff (rst)
        (tap_i.vld && !tap_i.is_q && one_bus) |=> (!lclk_o && bus_b_o == '0));

    // R5: the mode used for a Q word is the pin value seen one cycle earlier
    a_r5_mode_from_i: assert property (@(posedge clk) disable iff (rst)
        (tap_i.vld && tap_i.is_q && !$past(rst)) |-> (st_q.single == $past(one_bus)));
endmodule

// File: rtl/adc_pair_formatter.sv
module adc_pair_formatter
    import adcfmt_pkg::*;
#(
    parameter int unsigned LAT_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] conv_word,
    input  logic              one_bus,
    input  logic              hiz,
    output logic [WORD_W-1:0] bus_a,
    output logic [WORD_W-1:0] bus_b,
    output logic              bus_en,
    output logic              lclk,
    output logic              lclk_n
);
    localparam int unsigned DLY_STAGES = (LAT_CYCLES > 1) ? LAT_CYCLES - 1 : 0;

    tagged_t smp;
    tagged_t tap;

    adcfmt_tagger u_tagger (
        .clk    (clk),
        .rst    (rst),
        .word_i (conv_word),
        .smp_o  (smp)
    );

    adcfmt_delay #(.DEPTH(DLY_STAGES)) u_delay (
        .clk (clk),
        .rst (rst),
        .d_i (smp),
        .q_o (tap)
    );

    adcfmt_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .one_bus (one_bus),
        .tap_i   (tap),
        .bus_a_o (bus_a),
        .bus_b_o (bus_b),
        .lclk_o  (lclk)
    );

    assign lclk_n = ~lclk;
    assign bus_en = ~hiz;

    // R8: a reset cycle leaves all data outputs and the latch clock low
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (bus_a == '0 && bus_b == '0 && !lclk));
endmodule

// File: tb/adc_pair_formatter_bench.sv
module adc_pair_formatter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] conv_word = 8'h00;
    logic       one_bus = 1'b1;
    logic       hiz = 1'b0;
    logic [7:0] bus_a, bus_b;
    logic       bus_en, lclk, lclk_n;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] wv [0:1023];
    logic       mv [0:1023];
    int         m;
    logic [7:0] ea, eb;
    logic       el;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pair_formatter #(.LAT_CYCLES(LAT)) u_adc_pair_formatter (
        .clk(clk), .rst(rst), .conv_word(conv_word), .one_bus(one_bus),
        .hiz(hiz), .bus_a(bus_a), .bus_b(bus_b), .bus_en(bus_en),
        .lclk(lclk), .lclk_n(lclk_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at step %0d: actual %0h expected %0h", req, m, act, exp);
        end
    endtask

    function automatic string step_tag(input int k, input string phase);
        if (k < 1) return "R8";
        if (k == 1) return "R1";
        return phase;
    endfunction

    // model of the output registers after edge m, from the requirements
    task automatic model_step();
        int k;
        k = m - LAT;
        if (k < 1) return;
        if (k % 2 == 1) begin
            if (mv[m]) begin ea = wv[k]; eb = 8'h00; el = 1'b0; end
        end else begin
            if (mv[m-1]) begin ea = wv[k]; eb = 8'h00; el = 1'b1; end
            else begin ea = wv[k-1]; eb = wv[k]; el = ~el; end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        m = 0;
        chk("R8", bus_a, 0);
        chk("R8", bus_b, 0);
        chk("R8", lclk, 0);
        ea = 8'h00; eb = 8'h00; el = 1'b0;
        rst = 1'b0;
    endtask

    task automatic run_cycle(input logic [7:0] w, input logic mb, input logic hz, input string phase);
        wv[m+1] = w;
        mv[m+1] = mb;
        conv_word = w;
        one_bus = mb;
        hiz = hz;
        #1;
        chk("R6", bus_en, !hz);
        @(negedge clk);
        m++;
        model_step();
        chk(step_tag(m - LAT, phase), bus_a, ea);
        chk(step_tag(m - LAT, phase), bus_b, eb);
        chk(step_tag(m - LAT, phase), lclk, el);
        chk("R7", lclk_n, !lclk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        do_reset();
        // single bus, latency and interleave, corner words first
        run_cycle(8'hFF, 1'b1, 1'b0, "R3");
        run_cycle(8'h00, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 40; i++) run_cycle(8'($urandom), 1'b1, 1'b0, "R2");
        for (int i = 0; i < 40; i++) run_cycle(8'($urandom), 1'b1, 1'b0, "R3");
        // dual bus, pairs aligned
        for (int i = 0; i < 60; i++) run_cycle(8'($urandom), 1'b0, 1'b0, "R4");
        // mode pin flipping every clock: pair boundary sampling
        for (int i = 0; i < 60; i++) run_cycle(8'($urandom), i[0], 1'b0, "R5");
        // random mode and high-impedance requests
        for (int i = 0; i < 200; i++)
            run_cycle(8'($urandom), ($urandom % 5) == 0 ? ~one_bus : one_bus,
                      1'($urandom), "R6");
        // restart mid-run in dual mode
        do_reset();
        run_cycle(8'h00, 1'b0, 1'b0, "R4");
        run_cycle(8'hFF, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 30; i++) run_cycle(8'($urandom), 1'b0, 1'b1, "R4");
        // high-impedance toggled between clock edges
        hiz = 1'b1; #1; chk("R6", bus_en, 0);
        hiz = 1'b0; #1; chk("R6", bus_en, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule